// File: doc/BRIEF.md
# Pointing-Device Packet Encoder with Receive Queue

This block takes one pointing-device event at a time (a one-cycle strobe together with a signed horizontal delta, a signed vertical delta and three button states) and turns it into a fixed five-byte report. It writes the bytes, one per clock, into a byte-wide receive queue. A host drains the queue one byte at a time.

The report starts with a header byte whose three low bits are the buttons, active low. Next come the horizontal delta and the inverted vertical delta, each clamped to a symmetric 8-bit range. Two zero pad bytes close the report. While a report is being written the encoder is busy and drops any new event. The queue drops bytes offered while it is full. Reading an empty queue gives zero and has no other effect. A synchronous clear input empties the queue.

Top module: `mouse_packet_enc`

## Requirements
- R1: Byte 0 of a report is 0x87 with bit 2 cleared when `evt_btn[2]` (left) is 1, bit 1 cleared when `evt_btn[1]` (middle) is 1, and bit 0 cleared when `evt_btn[0]` (right) is 1.
- R2: Byte 1 is the 12-bit signed `evt_dx` clamped to −127..+127 before it is cut to 8 bits, in two's complement (for example +300 gives 0x7F and −2048 gives 0x81).
- R3: Byte 2 is the negation of the 12-bit signed `evt_dy`, clamped to −127..+127 (for example +3 gives 0xFD, −2048 gives 0x7F and +2047 gives 0x81).
- R4: Bytes 3 and 4 are always 0x00, and the five bytes enter the queue in the order 0, 1, 2, 3, 4.
- R5: An event accepted at a clock edge makes `busy` high for the next five cycles. One byte is written at each of the five edges that follow the accepting edge.
- R6: An event strobed while `busy` is high is ignored and adds no bytes.
- R7: The queue holds 256 bytes. A byte offered while the queue holds 256 bytes is dropped, even when a read happens in the same cycle.
- R8: While the queue is empty, `rd_data` is 0x00. A read (`rd_en`) of an empty queue changes nothing, so later bytes come out in order.
- R9: `data_avail` is high exactly when the queue holds at least one byte. `rd_data` shows the oldest byte, and `rd_en` removes it at the clock edge.
- R10: `clr` high at a clock edge empties the queue. It takes priority over a read or a write in the same cycle.
- R11: After reset the queue is empty, `data_avail` and `busy` are low, and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous queue clear |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_dx | input | 12 | Horizontal delta, signed |
| evt_dy | input | 12 | Vertical delta, signed |
| evt_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| rd_en | input | 1 | Remove the oldest byte at this edge |
| rd_data | output | 8 | Oldest queued byte, or 0x00 when empty |
| data_avail | output | 1 | Queue is not empty |
| busy | output | 1 | A report is being written |

## Verification
The hardest case to reach is a full queue that still gets offered bytes, because a report adds only five bytes and the host normally drains the queue. To get there, the stimulus sends 52 back-to-back events with reads held off. That offers 260 bytes, so the last four are dropped. The stimulus then drains all 256 bytes while a reference model checks that every byte that arrives is the right one. Reads of an empty queue and a clear that lands in the middle of a report are driven on purpose, to show that the pointers stay consistent after both.

// File: rtl/mspkt_pkg.sv
package mspkt_pkg;
  localparam int PKT_LEN = 5;
  localparam int SAT_MAX = 127;

  typedef logic [7:0] byte_t;
  typedef logic [PKT_LEN-1:0][7:0] frame_t;

  // Clamp a signed integer to the symmetric +/-SAT_MAX range, then cut to 8 bits.
  function automatic byte_t clamp_s8(input int v);
    int c;
    c = v;
    if (c > SAT_MAX) c = SAT_MAX;
    else if (c < -SAT_MAX) c = -SAT_MAX;
    return byte_t'(c);
  endfunction

  // Header byte: top bit set, buttons active low in the low three bits.
  function automatic byte_t header_byte(input logic [2:0] btn);
    return {5'b10000, ~btn};
  endfunction

  function automatic frame_t build_frame(input int dx, input int dy,
                                         input logic [2:0] btn);
    frame_t f;
    f[0] = header_byte(btn);
    f[1] = clamp_s8(dx);
    f[2] = clamp_s8(-dy);
    for (int i = 3; i < PKT_LEN; i++) f[i] = 8'h00;
    return f;
  endfunction
endpackage

// File: rtl/mspkt_encoder.sv
module mspkt_encoder
  import mspkt_pkg::*;
#(
  parameter int DELTA_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      evt_valid,
  input  logic signed [DELTA_W-1:0] evt_dx,
  input  logic signed [DELTA_W-1:0] evt_dy,
  input  logic [2:0]                evt_btn,
  output logic                      push_req,
  output logic [7:0]                push_byte,
  output logic                      busy
);
  localparam int IW = $clog2(PKT_LEN);

  frame_t        frame_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic          accept;
  logic          last_byte;

  assign accept    = evt_valid && !busy_q;
  assign last_byte = (idx_q == IW'(PKT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (accept) begin
      frame_q <= build_frame(int'(evt_dx), int'(evt_dy), evt_btn);
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (last_byte) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign push_req  = busy_q;
  assign push_byte = frame_q[idx_q];
  assign busy      = busy_q;
endmodule

// File: rtl/mspkt_fifo.sv
module mspkt_fifo #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push_req,
  input  logic [7:0]               push_byte,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  output logic                     data_avail,
  output logic                     push_ok,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   count_q;
  logic          full, empty, pop_ok;

  assign full    = (count_q == (AW+1)'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push_req && !full && !clr;
  assign pop_ok  = rd_en && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (clr) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data    = empty ? 8'h00 : mem[rptr_q];
  assign data_avail = !empty;
  assign count      = count_q;
endmodule

// File: rtl/mouse_packet_enc.sv
module mouse_packet_enc #(
  parameter int DELTA_W    = 12,
  parameter int FIFO_DEPTH = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               evt_valid,
  input  logic [DELTA_W-1:0] evt_dx,
  input  logic [DELTA_W-1:0] evt_dy,
  input  logic [2:0]         evt_btn,
  input  logic               rd_en,
  output logic [7:0]         rd_data,
  output logic               data_avail,
  output logic               busy
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic          push_req;
  logic [7:0]    push_byte;
  logic          push_ok;
  logic [CW-1:0] fifo_count;

  mspkt_encoder #(.DELTA_W(DELTA_W)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_dx    ($signed(evt_dx)),
    .evt_dy    ($signed(evt_dy)),
    .evt_btn   (evt_btn),
    .push_req  (push_req),
    .push_byte (push_byte),
    .busy      (busy)
  );

  mspkt_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .push_req   (push_req),
    .push_byte  (push_byte),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .data_avail (data_avail),
    .push_ok    (push_ok),
    .count      (fifo_count)
  );
endmodule

// File: rtl/mspkt_checker.sv
module mspkt_checker #(
  parameter int DEPTH = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr,
  input logic                   rd_en,
  input logic                   evt_valid,
  input logic                   busy,
  input logic                   data_avail,
  input logic [7:0]             rd_data,
  input logic                   push_req,
  input logic                   push_ok,
  input logic [$clog2(DEPTH):0] fifo_count
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CW'(DEPTH) && push_req && !rd_en && !clr) |=> fifo_count == CW'(DEPTH));

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0 && rd_en && !push_req && !clr) |=> (fifo_count == '0));

  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> rd_data == 8'h00);

  assert_avail_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> $past(push_ok));

  assert_clr_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_avail);

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(evt_valid));

  assert_busy_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

bind mouse_packet_enc mspkt_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .rd_en      (rd_en),
  .evt_valid  (evt_valid),
  .busy       (busy),
  .data_avail (data_avail),
  .rd_data    (rd_data),
  .push_req   (push_req),
  .push_ok    (push_ok),
  .fifo_count (fifo_count)
);

// File: tb/test_mouse_packet_enc.sv
module test_mouse_packet_enc;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        evt_valid = 1'b0;
  logic [11:0] evt_dx = '0;
  logic [11:0] evt_dy = '0;
  logic [2:0]  evt_btn = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        data_avail;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  mouse_packet_enc i_mouse_packet_enc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
    .evt_dx(evt_dx), .evt_dy(evt_dy), .evt_btn(evt_btn), .rd_en(rd_en),
    .rd_data(rd_data), .data_avail(data_avail), .busy(busy)
  );

  // Behavioural reference model
  byte unsigned q[$];
  byte unsigned pend[$];

  function automatic byte unsigned clampv(int v);
    if (v > 127) return 8'd127;
    if (v < -127) return 8'd129;
    return byte'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      pend.delete();
    end else begin
      int pre_n;
      bit was_busy;
      pre_n = q.size();
      was_busy = (pend.size() != 0);
      if (clr) q.delete();
      else begin
        if (rd_en && pre_n > 0) void'(q.pop_front());
        if (was_busy && pre_n < DEPTH) q.push_back(pend[0]);
      end
      if (was_busy) void'(pend.pop_front());
      if (evt_valid && !was_busy) begin
        int dx, dy;
        byte unsigned h;
        dx = int'($signed(evt_dx));
        dy = int'($signed(evt_dy));
        h = 8'h87;
        if (evt_btn[2]) h = h - 8'd4;
        if (evt_btn[1]) h = h - 8'd2;
        if (evt_btn[0]) h = h - 8'd1;
        pend.push_back(h);
        pend.push_back(clampv(dx));
        pend.push_back(clampv(0 - dy));
        pend.push_back(8'h00);
        pend.push_back(8'h00);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int em = (q.size() != 0) ? int'(q[0]) : 0;
      check(rd_data == em[7:0], "R9 rd_data", rd_data, em);
      check(data_avail == (q.size() != 0), "R9 data_avail", data_avail, q.size() != 0);
      check(busy == (pend.size() != 0), "R5 busy", busy, pend.size() != 0);
    end
  end

  task automatic send(input int dx, input int dy, input logic [2:0] b);
    evt_valid = 1'b1; evt_dx = 12'(dx); evt_dy = 12'(dy); evt_btn = b;
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string req);
    check(rd_data == exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(data_avail == 1'b0, "R11", data_avail, 0);
    check(busy == 1'b0, "R11", busy, 0);
    check(rd_data == 8'h00, "R11", rd_data, 0);
    @(negedge clk);

    // R1 R2 R3 R4: small deltas, left button
    send(5, 3, 3'b100);
    rd_expect(8'h83, "R1"); rd_expect(8'h05, "R2"); rd_expect(8'hFD, "R3");
    rd_expect(8'h00, "R4"); rd_expect(8'h00, "R4");

    // Saturation, middle+right
    send(300, -500, 3'b011);
    rd_expect(8'h84, "R1"); rd_expect(8'h7F, "R2"); rd_expect(8'h7F, "R3");
    rd_expect(8'h00, "R4"); rd_expect(8'h00, "R4");

    // Extremes, all buttons
    send(-2048, 2047, 3'b111);
    rd_expect(8'h80, "R1"); rd_expect(8'h81, "R2"); rd_expect(8'h81, "R3");
    rd_expect(8'h00, "R4"); rd_expect(8'h00, "R4");
    send(0, -2048, 3'b000);
    rd_expect(8'h87, "R1"); rd_expect(8'h00, "R2"); rd_expect(8'h7F, "R3");
    rd_expect(8'h00, "R4"); rd_expect(8'h00, "R4");

    // R6: second strobe while busy is dropped
    evt_valid = 1'b1; evt_dx = 12'd1; evt_dy = 12'd1; evt_btn = 3'b000;
    @(negedge clk);
    check(busy == 1'b1, "R5", busy, 1);
    evt_dx = 12'd9; evt_btn = 3'b111;
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (5) @(negedge clk);
    rd_expect(8'h87, "R6"); rd_expect(8'h01, "R6"); rd_expect(8'hFF, "R6");
    rd_expect(8'h00, "R6"); rd_expect(8'h00, "R6");
    check(data_avail == 1'b0, "R6", data_avail, 0);

    // R8: empty reads return zero and do not disturb the pointers
    rd_expect(8'h00, "R8"); rd_expect(8'h00, "R8");
    send(-7, -1, 3'b010);
    rd_expect(8'h85, "R8"); rd_expect(8'hF9, "R8"); rd_expect(8'h01, "R8");
    rd_expect(8'h00, "R8"); rd_expect(8'h00, "R8");

    // R7: overfill with 52 reports (260 bytes), then drain 256
    for (int k = 0; k < 52; k++) send(k * 3 - 70, 40 - k, 3'(k));
    check(q.size() == DEPTH, "R7 model depth", q.size(), DEPTH);
    check(data_avail == 1'b1, "R7", data_avail, 1);
    for (int k = 0; k < DEPTH; k++) begin
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
    check(data_avail == 1'b0, "R7 drained", data_avail, 0);

    // R10: clear in the middle of a report, with a read in the same cycle
    send(2, 2, 3'b000);
    evt_valid = 1'b1; evt_dx = 12'd4; evt_dy = 12'd0; evt_btn = 3'b001;
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clr = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    clr = 1'b0; rd_en = 1'b0;
    check(data_avail == 1'b0, "R10", data_avail, 0);
    repeat (4) @(negedge clk);
    rd_expect(8'h00, "R10"); rd_expect(8'h00, "R10");
    check(data_avail == 1'b0, "R10", data_avail, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule